// File: doc/BRIEF.md
# Shadowed RTC Register Synchronizer

This block is the bus-facing register file of a real-time clock whose timekeeping state sits in a slow, always-on domain. Software writes never reach that domain directly. Each write lands in a fast-domain shadow copy of its register. A copy engine, paced by a slow-domain strobe, then moves those shadows across one register at a time, in a fixed priority order.

Reads of a synchronized register return the slow-domain copy. Software therefore sees a new value only after its copy has committed. A status word exposes two bitmaps. The stale bitmap shows which shadows still wait for a copy. The new bitmap shows which copies completed since status was last read. Each writable register also answers at two alias offsets, which OR bits in or clear bits out. A request bit in the second persistent register makes the engine copy every shadow again.

The eight copy slots follow a fixed order. Slots 0 and 1 are the two persistent registers. Slots 2 to 5 are reserved and never become stale. Slot 6 is the alarm and slot 7 is the seconds count. The engine scans from slot 0 upward, so this order is also the service priority.

Top module: `rtc_shadow_sync`

## Requirements
- R1: After reset, all shadows, slow-domain copies, the control and watchdog registers, and both bitmaps are zero. Status bit 31 reads as 1.
- R2: Bus addresses must be word aligned (addr[1:0]=0). addr[3:2] selects the write mode: 0 stores wdata, 1 ORs wdata into the register, 2 clears the bits set in wdata, and 3 is ignored. Register bases are control 0x00, status 0x10 (read-only), seconds 0x30, alarm 0x40, watchdog 0x50, persistent0 0x60 and persistent1 0x70.
- R3: A write in any mode to a synchronized register sets its stale bit at status[16+slot] in the following cycle. Slots are persistent0=0, persistent1=1, alarm=6 and seconds=7. Status bits 18 to 21 stay 0.
- R4: A read of a synchronized register returns its slow-domain copy, not the shadow. The control and watchdog registers read back directly.
- R5: When the engine is idle, a strobe on slow_tick launches a copy of the lowest-numbered stale slot. The next strobe commits that copy and, in the same cycle, launches the lowest slot that is still stale.
- R6: No slow-domain copy changes in a cycle without a strobe, however long the wait.
- R7: If a register is rewritten while its copy is in flight, the in-flight value still commits. The stale bit then stays set, and a second copy carries the newer value.
- R8: Each commit sets bit 8+slot of status. A status read returns these bits and then clears them.
- R9: A write that leaves bit 31 of persistent1 set marks all four synchronized slots stale. Bit 31 itself is never stored and reads back as 0.
- R10: Status bit 28 mirrors the xtal_32000_det input, and status bit 27 mirrors the xtal_32768_det input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe that paces the slow domain |
| xtal_32000_det | input | 1 | 32000 Hz crystal detected |
| xtal_32768_det | input | 1 | 32768 Hz crystal detected |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request (clears the new bitmap on a status read) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, an 8-bit address and the fixed eight-slot copy order. With only four live slots, a single force request exercises the whole scan in five strobes. Because the strobe is an input, the bench can hold it low for a long stretch, or raise it for a single cycle. This lets a rewrite land between the launch and the commit of the same slot, so the requeue case of R7 can be hit on purpose.

// File: rtl/rtc_sync_pkg.sv
package rtc_sync_pkg;

    localparam int NSLOT = 8;
    localparam int SLOT_W = $clog2(NSLOT);

    // copy order: persistent0, persistent1, four reserved, alarm, seconds
    localparam int SLOT_P0  = 0;
    localparam int SLOT_P1  = 1;
    localparam int SLOT_ALM = 6;
    localparam int SLOT_SEC = 7;
    localparam logic [NSLOT-1:0] SYNC_MASK = 8'hC3;

    localparam int STALE_LSB = 16;
    localparam int NEW_LSB   = 8;
    localparam int PRESENT_BIT = 31;
    localparam int X32000_BIT  = 28;
    localparam int X32768_BIT  = 27;

    localparam logic [7:0] BASE_CTRL = 8'h00;
    localparam logic [7:0] BASE_STAT = 8'h10;
    localparam logic [7:0] BASE_SEC  = 8'h30;
    localparam logic [7:0] BASE_ALM  = 8'h40;
    localparam logic [7:0] BASE_WDOG = 8'h50;
    localparam logic [7:0] BASE_P0   = 8'h60;
    localparam logic [7:0] BASE_P1   = 8'h70;

    typedef enum logic [1:0] {
        OP_STORE = 2'd0,
        OP_OR    = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } wr_op_e;

endpackage

// File: rtl/rtc_alias_merge.sv
module rtc_alias_merge
    import rtc_sync_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] wdata,
    input  wr_op_e            op,
    output logic [DATA_W-1:0] merged
);

    always_comb begin
        unique case (op)
            OP_STORE: merged = wdata;
            OP_OR:    merged = old_val | wdata;
            OP_CLEAR: merged = old_val & ~wdata;
            default:  merged = old_val;
        endcase
    end

endmodule

// File: rtl/rtc_lowest_pick.sv
module rtc_lowest_pick #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    logic [N-1:0] below;
    logic [N-1:0] grant;

    assign below[0] = 1'b0;
    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_chain
            assign below[g] = below[g-1] | req[g-1];
        end
    endgenerate

    assign grant = req & ~below;
    assign found = |req;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/rtc_shadow_sync.sv
module rtc_shadow_sync
    import rtc_sync_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              xtal_32000_det,
    input  logic              xtal_32768_det,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int FORCE_BIT = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0]             ctrl;
        logic [DATA_W-1:0]             wdog;
        logic [NSLOT-1:0][DATA_W-1:0]  shadow;
        logic [NSLOT-1:0][DATA_W-1:0]  dom;
        logic [NSLOT-1:0]              stale;
        logic [NSLOT-1:0]              newr;
        logic                          busy;
        logic [SLOT_W-1:0]             idx;
        logic                          redo;
        logic [DATA_W-1:0]             buf_val;
    } state_t;

    state_t st_q, st_d;

    logic [7:0]        base;
    wr_op_e            op;
    logic              aligned;
    logic [DATA_W-1:0] old_sel;
    logic [DATA_W-1:0] merged;
    logic [NSLOT-1:0]  commit_clr;
    logic [NSLOT-1:0]  stale_after;
    logic              pick_found;
    logic [SLOT_W-1:0] pick_idx;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign op      = wr_op_e'(bus_addr[3:2]);
    assign base    = 8'({bus_addr[ADDR_W-1:4], 4'b0000});

    always_comb begin
        unique case (base)
            BASE_CTRL: old_sel = st_q.ctrl;
            BASE_WDOG: old_sel = st_q.wdog;
            BASE_SEC:  old_sel = st_q.shadow[SLOT_SEC];
            BASE_ALM:  old_sel = st_q.shadow[SLOT_ALM];
            BASE_P0:   old_sel = st_q.shadow[SLOT_P0];
            BASE_P1:   old_sel = st_q.shadow[SLOT_P1];
            default:   old_sel = '0;
        endcase
    end

    rtc_alias_merge #(.DATA_W(DATA_W)) u_merge (
        .old_val (old_sel),
        .wdata   (bus_wdata),
        .op      (op),
        .merged  (merged)
    );

    // a committing slot leaves the queue unless rewritten during its flight
    always_comb begin
        commit_clr = '0;
        if (slow_tick && st_q.busy && !st_q.redo) commit_clr[st_q.idx] = 1'b1;
        stale_after = st_q.stale & ~commit_clr;
    end

    rtc_lowest_pick #(.N(NSLOT)) u_pick (
        .req   (stale_after & SYNC_MASK),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        logic [NSLOT-1:0]  stale_set;
        logic [DATA_W-1:0] val;
        logic              force_all;
        logic              slot_hit;
        logic [SLOT_W-1:0] slot;

        st_d      = st_q;
        stale_set = '0;
        force_all = 1'b0;
        slot_hit  = 1'b0;
        slot      = '0;
        val       = merged;

        if (bus_wr && aligned && op != OP_NONE) begin
            unique case (base)
                BASE_CTRL: st_d.ctrl = merged;
                BASE_WDOG: st_d.wdog = merged;
                BASE_SEC:  begin slot_hit = 1'b1; slot = SLOT_W'(SLOT_SEC); end
                BASE_ALM:  begin slot_hit = 1'b1; slot = SLOT_W'(SLOT_ALM); end
                BASE_P0:   begin slot_hit = 1'b1; slot = SLOT_W'(SLOT_P0);  end
                BASE_P1:   begin
                    slot_hit       = 1'b1;
                    slot           = SLOT_W'(SLOT_P1);
                    force_all      = merged[FORCE_BIT];
                    val[FORCE_BIT] = 1'b0;
                end
                default: ;
            endcase
        end

        if (slot_hit) begin
            st_d.shadow[slot] = val;
            stale_set[slot]   = 1'b1;
        end
        if (force_all) stale_set = stale_set | SYNC_MASK;

        if (bus_rd && aligned && base == BASE_STAT) st_d.newr = '0;

        if (slow_tick) begin
            if (st_q.busy) begin
                st_d.dom[st_q.idx]  = st_q.buf_val;
                st_d.newr[st_q.idx] = 1'b1;
            end
            st_d.busy    = pick_found;
            st_d.idx     = pick_idx;
            st_d.buf_val = st_q.shadow[pick_idx];
            st_d.redo    = pick_found && stale_set[pick_idx];
        end else if (st_q.busy && stale_set[st_q.idx]) begin
            st_d.redo = 1'b1;
        end

        st_d.stale = stale_after | stale_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (base)
                BASE_CTRL: bus_rdata = st_q.ctrl;
                BASE_WDOG: bus_rdata = st_q.wdog;
                BASE_SEC:  bus_rdata = st_q.dom[SLOT_SEC];
                BASE_ALM:  bus_rdata = st_q.dom[SLOT_ALM];
                BASE_P0:   bus_rdata = st_q.dom[SLOT_P0];
                BASE_P1:   bus_rdata = st_q.dom[SLOT_P1];
                BASE_STAT: begin
                    bus_rdata[PRESENT_BIT]                 = 1'b1;
                    bus_rdata[X32000_BIT]                  = xtal_32000_det;
                    bus_rdata[X32768_BIT]                  = xtal_32768_det;
                    bus_rdata[STALE_LSB +: NSLOT]          = st_q.stale;
                    bus_rdata[NEW_LSB +: NSLOT]            = st_q.newr;
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    AST_WRITE_MARKS_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(BASE_SEC)) |=> st_q.stale[SLOT_SEC]); // R3

    AST_COPY_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_tick |=> $stable(st_q.dom)); // R6

    AST_COMMIT_CARRIES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_tick && st_q.busy) |=> st_q.dom[$past(st_q.idx)] == $past(st_q.buf_val)); // R5

    AST_FORCE_ALL_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(BASE_P1) && bus_wdata[FORCE_BIT])
        |=> ((st_q.stale & SYNC_MASK) == SYNC_MASK)); // R9

    AST_NEW_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(BASE_STAT) && !slow_tick) |=> st_q.newr == '0); // R8

    AST_FORCE_BIT_NOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> !(st_q.idx == SLOT_W'(SLOT_P1) && st_q.buf_val[FORCE_BIT])); // R9

endmodule

// File: tb/tb_rtc_shadow_sync.sv
module tb_rtc_shadow_sync;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        xtal_32000_det = 1'b1;
    logic        xtal_32768_det = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fail = 0;

    localparam logic [31:0] STAT_FIXED = 32'h9000_0000;

    always #5 clk = ~clk;

    rtc_shadow_sync dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
        .xtal_32000_det(xtal_32000_det), .xtal_32768_det(xtal_32768_det),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] stale_of(input logic [31:0] s);
        return s[23:16];
    endfunction

    function automatic logic [7:0] new_of(input logic [31:0] s);
        return s[15:8];
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h10, v);
        check("R1 status after reset", v, STAT_FIXED);
        check("R10 crystal bits", {3'b0, v[28:27], 27'b0}, 32'h1000_0000);
        rd(8'h30, v);
        check("R1 seconds after reset", v, 32'h0);
        rd(8'h00, v);
        check("R1 control after reset", v, 32'h0);
    endtask

    task automatic t_alias_plain;
        logic [31:0] v;
        wr(8'h00, 32'h0000_00F0);
        wr(8'h04, 32'h0000_0003);
        rd(8'h00, v);
        check("R2 control OR alias", v, 32'h0000_00F3);
        wr(8'h08, 32'h0000_0030);
        rd(8'h00, v);
        check("R2 control clear alias", v, 32'h0000_00C3);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h00, v);
        check("R2 mode 3 ignored", v, 32'h0000_00C3);
        wr(8'h50, 32'h0000_1234);
        rd(8'h50, v);
        check("R4 watchdog direct readback", v, 32'h0000_1234);
    endtask

    task automatic t_single_copy;
        logic [31:0] v;
        wr(8'h30, 32'd100);
        rd(8'h10, v);
        check("R3 seconds stale bit", {24'b0, stale_of(v)}, 32'h80);
        rd(8'h30, v);
        check("R4 seconds not yet visible", v, 32'd0);
        strobe(1);
        rd(8'h30, v);
        check("R5 launch does not commit", v, 32'd0);
        rd(8'h10, v);
        check("R5 stale held during flight", {24'b0, stale_of(v)}, 32'h80);
        strobe(1);
        rd(8'h30, v);
        check("R4 seconds after commit", v, 32'd100);
        rd(8'h10, v);
        check("R8 new bit after commit", {16'b0, stale_of(v), new_of(v)}, 32'h0000_0080);
        rd(8'h10, v);
        check("R8 new bits cleared by read", {24'b0, new_of(v)}, 32'h0);
    endtask

    task automatic t_order;
        logic [31:0] v;
        wr(8'h40, 32'd5);
        wr(8'h60, 32'h0000_000A);
        rd(8'h10, v);
        check("R3 alarm and p0 stale", {24'b0, stale_of(v)}, 32'h41);
        strobe(2);
        rd(8'h60, v);
        check("R5 lowest slot first", v, 32'h0000_000A);
        rd(8'h40, v);
        check("R5 alarm still pending", v, 32'd0);
        strobe(1);
        rd(8'h40, v);
        check("R5 alarm committed next", v, 32'd5);
        rd(8'h10, v);
        check("R8 new bits for both", {16'b0, stale_of(v), new_of(v)}, 32'h0000_0041);
    endtask

    task automatic t_hold_and_requeue;
        logic [31:0] v;
        wr(8'h30, 32'd200);
        repeat (40) @(negedge clk);
        rd(8'h30, v);
        check("R6 no change without strobe", v, 32'd100);
        strobe(1);
        wr(8'h30, 32'd300);
        strobe(1);
        rd(8'h30, v);
        check("R7 in-flight value commits", v, 32'd200);
        rd(8'h10, v);
        check("R7 stale kept after rewrite", {24'b0, stale_of(v)}, 32'h80);
        strobe(1);
        rd(8'h30, v);
        check("R7 second copy carries new value", v, 32'd300);
        rd(8'h10, v);
        check("R7 stale clears after requeue", {24'b0, stale_of(v)}, 32'h0);
    endtask

    task automatic t_alias_synced;
        logic [31:0] v;
        wr(8'h34, 32'h0000_0001);
        strobe(2);
        rd(8'h30, v);
        check("R2 OR alias on seconds", v, 32'd301);
        wr(8'h38, 32'h0000_0100);
        rd(8'h10, v);
        check("R3 clear alias marks stale", {24'b0, stale_of(v)}, 32'h80);
        strobe(2);
        rd(8'h30, v);
        check("R2 clear alias on seconds", v, 32'd45);
    endtask

    task automatic t_force;
        logic [31:0] v;
        rd(8'h10, v);
        wr(8'h70, 32'h8000_0011);
        rd(8'h10, v);
        check("R9 force marks all slots", {24'b0, stale_of(v)}, 32'hC3);
        check("R3 reserved slots stay clear", {28'b0, stale_of(v)[5:2]}, 32'h0);
        strobe(5);
        rd(8'h70, v);
        check("R9 force bit not stored", v, 32'h0000_0011);
        rd(8'h60, v);
        check("R9 p0 recopied unchanged", v, 32'h0000_000A);
        rd(8'h10, v);
        check("R9 all copies done", {16'b0, stale_of(v), new_of(v)}, 32'h0000_00C3);
        xtal_32000_det = 1'b0; xtal_32768_det = 1'b1;
        rd(8'h10, v);
        check("R10 crystal bits follow inputs", v, 32'h8800_0000);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alias_plain();
        t_single_copy();
        t_order();
        t_hold_and_requeue();
        t_alias_synced();
        t_force();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule